// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block takes a reference frequency and a wanted output frequency, both in Hz. It then searches for a clock synthesiser setting made of three parts: a pre-divider R, a feedback multiplier F and an output shift OD. The synthesised clock is ((ref / R) × F) >> OD. The engine keeps the best-scoring setting whose output lands inside a narrow tolerance band around the target. It returns R, F, a two-bit post-divider code, the frequency actually achieved, and a flag that tells whether any setting was acceptable.

Every quotient comes from one shared 32-bit restoring divider, which produces one quotient bit per clock. The search state machine waits while each division runs. The caller raises `start` for one cycle while the engine is idle. `busy` then stays high until the search ends. In the final cycle `done` pulses and the results are loaded, and they stay unchanged until the next accepted start. The search stops stepping F for a given R as soon as the output passes the upper band edge. This shortens the run but gives the same result as a full sweep.

Top module: `pll_param_search`

## Requirements
- R1: A `start` seen while idle raises `busy` on the next cycle. At the end of the search `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R2: A `start` seen while `busy` is high is ignored. The running search keeps the inputs it latched and returns the result for those inputs.
- R3: When a setting is found, `out_hz` lies within target ± (target >> 8), bounds included.
- R4: The shift OD is tried in the order 1, 2, 0. For each OD, R runs from 2 to 33. F starts at ((R × (target >> 8)) << OD, kept to 32 bits) / (ref >> 8), reduced by one if it is above 2. F then steps up by one while it stays within 2..513. When found, `r_sel` is in 2..33 and `f_sel` is in 2..513.
- R5: The VCO frequency is (ref / R) × F, computed without overflow. A candidate is valid only if the VCO is at least 100 MHz and at most 500 MHz. When the target itself exceeds 500 MHz, the upper limit becomes `VCO_ABS_MAX` (default 640 MHz).
- R6: Score = (ref/R − ref/33) / ((ref − ref/33) >> 10) + (VCO − 100 MHz) / 390625. The first valid candidate is always kept. A later one replaces it only if its score is greater than or equal to the best score and its OD is non-zero.
- R7: `p_code` is 3 when the chosen OD is 2, and otherwise equals the chosen OD (0 → 0, 1 → 1). The code 2 never appears.
- R8: If no candidate is valid, `done` pulses with `found` low, and `r_sel`, `f_sel`, `p_code` and `out_hz` are all zero.
- R9: The result outputs change only in the cycle where `done` is high. They hold their values across any input activity until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle search request, taken only when idle |
| ref_hz | input | 32 | Reference frequency in Hz |
| tgt_hz | input | 32 | Wanted output frequency in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when results are loaded |
| found | output | 1 | A valid setting was found |
| r_sel | output | 6 | Chosen pre-divider R |
| f_sel | output | 10 | Chosen feedback multiplier F |
| p_code | output | 2 | Encoded post-divider |
| out_hz | output | 32 | Achieved output frequency in Hz |

## Verification
The bound checker checks the following on every cycle:
- the handshake: busy follows an accepted start, done is a single pulse with busy low, and the results stay frozen outside done;
- that a reported frequency lies inside the band of the target captured at start;
- the legal ranges of R and F and the absence of code 2;
- the all-zero result when nothing is found.

Some behaviour can only be shown by the bench's scenarios, which compare against a behavioural sweep of the same search:
- that the search order, the F estimate, the VCO limits with their high-target override, and the score-and-tie rule pick exactly the expected setting;
- that a start during a search is ignored.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_INIT,
        S_RDIV,
        S_FEST,
        S_FSTEP,
        S_PHDIV,
        S_VDIV
    } srch_state_e;

    // Shift order of the outer loop: index 0 -> 1, 1 -> 2, 2 -> 0
    function automatic logic [1:0] od_at(input logic [1:0] idx);
        case (idx)
            2'd0:    od_at = 2'd1;
            2'd1:    od_at = 2'd2;
            default: od_at = 2'd0;
        endcase
    endfunction

    function automatic logic [1:0] p_encode(input logic [1:0] od);
        p_encode = (od >= 2'd2) ? 2'd3 : od;
    endfunction

endpackage

// File: rtl/pll_div.sv
module pll_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  den;
    } div_st_t;

    div_st_t q, n;
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        n       = q;
        n.done  = 1'b0;
        shifted = {q.rem, q.quo[W-1]};
        trial   = shifted - {1'b0, q.den};
        if (go && !q.busy) begin
            n.busy = 1'b1;
            n.cnt  = CW'(W);
            n.rem  = '0;
            n.quo  = dividend;
            n.den  = divisor;
        end else if (q.busy) begin
            if (!trial[W]) begin
                n.rem = trial[W-1:0];
                n.quo = {q.quo[W-2:0], 1'b1};
            end else begin
                n.rem = shifted[W-1:0];
                n.quo = {q.quo[W-2:0], 1'b0};
            end
            n.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                n.busy = 1'b0;
                n.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign done     = q.done;
    assign quotient = q.quo;

endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval #(
    parameter int          W           = 32,
    parameter int          FW          = 10,
    parameter int unsigned VCO_MIN     = 100_000_000,
    parameter int unsigned VCO_MAXR    = 500_000_000,
    parameter int unsigned VCO_ABS_MAX = 640_000_000
) (
    input  logic [W-1:0]    step_hz,
    input  logic [FW-1:0]   mult,
    input  logic [1:0]      od,
    input  logic [W-1:0]    tgt,
    input  logic [W:0]      lo,
    input  logic [W:0]      hi,
    output logic [W+FW-1:0] vco,
    output logic [W+FW-1:0] out_f,
    output logic            over,
    output logic            valid
);
    localparam int VW = W + FW;

    logic in_win;
    logic vco_ok;

    always_comb begin
        vco    = VW'(step_hz) * VW'(mult);
        out_f  = vco >> od;
        over   = out_f > VW'(hi);
        in_win = (out_f >= VW'(lo)) && !over;
        vco_ok = (vco >= VW'(VCO_MIN)) &&
                 ((vco <= VW'(VCO_MAXR)) ||
                  ((tgt > W'(VCO_MAXR)) && (vco <= VW'(VCO_ABS_MAX))));
        valid  = vco_ok && in_win;
    end

endmodule

// File: rtl/pll_param_search.sv
module pll_param_search
    import pllsrch_pkg::*;
#(
    parameter int          W           = 32,
    parameter int          R_MIN       = 2,
    parameter int          R_MAX       = 33,
    parameter int          F_MIN       = 2,
    parameter int          F_MAX       = 513,
    parameter int          SCALE       = 8,
    parameter int          SCORE_SHIFT = 10,
    parameter int unsigned VCO_MIN     = 100_000_000,
    parameter int unsigned VCO_MAXR    = 500_000_000,
    parameter int unsigned VCO_ABS_MAX = 640_000_000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [W-1:0]               ref_hz,
    input  logic [W-1:0]               tgt_hz,
    output logic                       busy,
    output logic                       done,
    output logic                       found,
    output logic [$clog2(R_MAX+1)-1:0] r_sel,
    output logic [$clog2(F_MAX+1)-1:0] f_sel,
    output logic [1:0]                 p_code,
    output logic [W-1:0]               out_hz
);
    localparam int          RW         = $clog2(R_MAX + 1);
    localparam int          FW         = $clog2(F_MAX + 1);
    localparam int          VW         = W + FW;
    localparam int unsigned VSCORE_DEN = (VCO_MAXR - VCO_MIN) >> SCORE_SHIFT;

    typedef struct packed {
        srch_state_e   state;
        logic [W-1:0]  ref_f;
        logic [W-1:0]  tgt_f;
        logic [W:0]    lo;
        logic [W:0]    hi;
        logic [W-1:0]  ref33;
        logic [W-1:0]  ph_den;
        logic [W-1:0]  qr;
        logic [W-1:0]  f;
        logic [W-1:0]  ph;
        logic [W-1:0]  cand_clk;
        logic [VW-1:0] vco;
        logic [1:0]    od_idx;
        logic [RW-1:0] r;
        logic          best_found;
        logic [W-1:0]  best_score;
        logic [RW-1:0] best_r;
        logic [FW-1:0] best_f;
        logic [1:0]    best_od;
        logic [W-1:0]  best_clk;
        logic          done_o;
        logic          found_o;
        logic [RW-1:0] r_o;
        logic [FW-1:0] f_o;
        logic [1:0]    p_o;
        logic [W-1:0]  hz_o;
    } st_t;

    st_t q, n;

    logic          div_go;
    logic [W-1:0]  div_a;
    logic [W-1:0]  div_b;
    logic          div_done;
    logic [W-1:0]  div_q;

    logic [1:0]    od_cur;
    logic [W-1:0]  est_num;
    logic [W-1:0]  score;
    logic [VW-1:0] cand_vco;
    logic [VW-1:0] cand_out;
    logic          cand_over;
    logic          cand_valid;
    logic          f_out_of_range;

    pll_div #(.W(W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_a),
        .divisor  (div_b),
        .done     (div_done),
        .quotient (div_q)
    );

    pll_cand_eval #(
        .W           (W),
        .FW          (FW),
        .VCO_MIN     (VCO_MIN),
        .VCO_MAXR    (VCO_MAXR),
        .VCO_ABS_MAX (VCO_ABS_MAX)
    ) u_eval (
        .step_hz (q.qr),
        .mult    (q.f[FW-1:0]),
        .od      (od_cur),
        .tgt     (q.tgt_f),
        .lo      (q.lo),
        .hi      (q.hi),
        .vco     (cand_vco),
        .out_f   (cand_out),
        .over    (cand_over),
        .valid   (cand_valid)
    );

    always_comb begin
        od_cur         = od_at(q.od_idx);
        est_num        = W'((W'(q.r) * (q.tgt_f >> SCALE)) << od_cur);
        score          = q.ph + div_q;
        f_out_of_range = (q.f < W'(F_MIN)) || (q.f > W'(F_MAX));
    end

    always_comb begin
        n        = q;
        n.done_o = 1'b0;
        div_go   = 1'b0;
        div_a    = '0;
        div_b    = '1;
        case (q.state)
            S_IDLE: begin
                if (start) begin
                    n.ref_f      = ref_hz;
                    n.tgt_f      = tgt_hz;
                    n.lo         = {1'b0, tgt_hz} - {1'b0, tgt_hz >> SCALE};
                    n.hi         = {1'b0, tgt_hz} + {1'b0, tgt_hz >> SCALE};
                    n.best_found = 1'b0;
                    n.best_score = '0;
                    div_go       = 1'b1;
                    div_a        = ref_hz;
                    div_b        = W'(R_MAX);
                    n.state      = S_INIT;
                end
            end
            S_INIT: begin
                if (div_done) begin
                    n.ref33  = div_q;
                    n.ph_den = (q.ref_f - div_q) >> SCORE_SHIFT;
                    n.od_idx = 2'd0;
                    n.r      = RW'(R_MIN);
                    div_go   = 1'b1;
                    div_a    = q.ref_f;
                    div_b    = W'(R_MIN);
                    n.state  = S_RDIV;
                end
            end
            S_RDIV: begin
                if (div_done) begin
                    n.qr    = div_q;
                    div_go  = 1'b1;
                    div_a   = est_num;
                    div_b   = q.ref_f >> SCALE;
                    n.state = S_FEST;
                end
            end
            S_FEST: begin
                if (div_done) begin
                    n.f     = (div_q > W'(F_MIN)) ? div_q - 1'b1 : div_q;
                    n.state = S_FSTEP;
                end
            end
            S_FSTEP: begin
                if (f_out_of_range || cand_over) begin
                    if (q.r == RW'(R_MAX)) begin
                        if (q.od_idx == 2'd2) begin
                            n.state   = S_IDLE;
                            n.done_o  = 1'b1;
                            n.found_o = q.best_found;
                            n.r_o     = q.best_found ? q.best_r : '0;
                            n.f_o     = q.best_found ? q.best_f : '0;
                            n.p_o     = q.best_found ? p_encode(q.best_od) : 2'd0;
                            n.hz_o    = q.best_found ? q.best_clk : '0;
                        end else begin
                            n.od_idx = q.od_idx + 1'b1;
                            n.r      = RW'(R_MIN);
                            div_go   = 1'b1;
                            div_a    = q.ref_f;
                            div_b    = W'(R_MIN);
                            n.state  = S_RDIV;
                        end
                    end else begin
                        n.r     = q.r + 1'b1;
                        div_go  = 1'b1;
                        div_a   = q.ref_f;
                        div_b   = W'(q.r + 1'b1);
                        n.state = S_RDIV;
                    end
                end else if (cand_valid) begin
                    n.vco      = cand_vco;
                    n.cand_clk = W'(cand_out);
                    div_go     = 1'b1;
                    div_a      = q.qr - q.ref33;
                    div_b      = q.ph_den;
                    n.state    = S_PHDIV;
                end else begin
                    n.f = q.f + 1'b1;
                end
            end
            S_PHDIV: begin
                if (div_done) begin
                    n.ph    = div_q;
                    div_go  = 1'b1;
                    div_a   = W'(q.vco - VW'(VCO_MIN));
                    div_b   = W'(VSCORE_DEN);
                    n.state = S_VDIV;
                end
            end
            S_VDIV: begin
                if (div_done) begin
                    if (!q.best_found || ((score >= q.best_score) && (od_cur != 2'd0))) begin
                        n.best_found = 1'b1;
                        n.best_score = score;
                        n.best_r     = q.r;
                        n.best_f     = q.f[FW-1:0];
                        n.best_od    = od_cur;
                        n.best_clk   = q.cand_clk;
                    end
                    n.f     = q.f + 1'b1;
                    n.state = S_FSTEP;
                end
            end
            default: n.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign busy   = (q.state != S_IDLE);
    assign done   = q.done_o;
    assign found  = q.found_o;
    assign r_sel  = q.r_o;
    assign f_sel  = q.f_o;
    assign p_code = q.p_o;
    assign out_hz = q.hz_o;

endmodule

// File: rtl/pll_search_chk.sv
module pll_search_chk #(
    parameter int W     = 32,
    parameter int RW    = 6,
    parameter int FW    = 10,
    parameter int R_MIN = 2,
    parameter int R_MAX = 33,
    parameter int F_MIN = 2,
    parameter int F_MAX = 513,
    parameter int SCALE = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [W-1:0]  tgt_hz,
    input logic          busy,
    input logic          done,
    input logic          found,
    input logic [RW-1:0] r_sel,
    input logic [FW-1:0] f_sel,
    input logic [1:0]    p_code,
    input logic [W-1:0]  out_hz
);
    logic [W-1:0] tgt_cap;
    logic [W:0]   lo_cap;
    logic [W:0]   hi_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               tgt_cap <= '0;
        else if (start && !busy)  tgt_cap <= tgt_hz;
    end

    assign lo_cap = {1'b0, tgt_cap} - {1'b0, tgt_cap >> SCALE};
    assign hi_cap = {1'b0, tgt_cap} + {1'b0, tgt_cap >> SCALE};

    p_busy_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);
    p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done && found |-> ({1'b0, out_hz} >= lo_cap) && ({1'b0, out_hz} <= hi_cap));
    p_legal_rf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done && found |-> (r_sel >= RW'(R_MIN)) && (r_sel <= RW'(R_MAX)) &&
                          (f_sel >= FW'(F_MIN)) && (f_sel <= FW'(F_MAX)));
    p_no_code2_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> p_code != 2'd2);
    p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && !found |-> (r_sel == '0) && (f_sel == '0) && (p_code == 2'd0) && (out_hz == '0));
    p_hold_results_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(found) && $stable(r_sel) && $stable(f_sel) &&
                  $stable(p_code) && $stable(out_hz));

endmodule

bind pll_param_search pll_search_chk #(
    .W     (W),
    .RW    (RW),
    .FW    (FW),
    .R_MIN (R_MIN),
    .R_MAX (R_MAX),
    .F_MIN (F_MIN),
    .F_MAX (F_MAX),
    .SCALE (SCALE)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .tgt_hz (tgt_hz),
    .busy   (busy),
    .done   (done),
    .found  (found),
    .r_sel  (r_sel),
    .f_sel  (f_sel),
    .p_code (p_code),
    .out_hz (out_hz)
);

// File: tb/tb_pll_param_search.sv
module tb_pll_param_search;

    localparam int unsigned REFC = 14_318_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ref_hz = '0;
    logic [31:0] tgt_hz = '0;
    logic        busy, done, found;
    logic [5:0]  r_sel;
    logic [9:0]  f_sel;
    logic [1:0]  p_code;
    logic [31:0] out_hz;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #2 clk = ~clk;

    pll_param_search dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_hz(ref_hz), .tgt_hz(tgt_hz),
        .busy(busy), .done(done), .found(found), .r_sel(r_sel), .f_sel(f_sel),
        .p_code(p_code), .out_hz(out_hz)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190_000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish actual=%0d expected=<190000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural sweep of the whole search space
    task automatic model(input int unsigned rf, input int unsigned tg,
                         output bit fnd, output int unsigned br, output int unsigned bf,
                         output int unsigned bp, output longint bclk);
        longint lo, hi, vco, o, sc, bsc;
        int unsigned ref33, phden, qr, e, f, bod;
        int odl[3];
        odl[0] = 1; odl[1] = 2; odl[2] = 0;
        lo = longint'(tg) - longint'(tg >> 8);
        hi = longint'(tg) + longint'(tg >> 8);
        ref33 = rf / 33;
        phden = (rf - ref33) >> 10;
        fnd = 0; br = 0; bf = 0; bod = 0; bclk = 0; bsc = 0;
        for (int oi = 0; oi < 3; oi++) begin
            for (int unsigned r = 2; r <= 33; r++) begin
                e = (r * (tg >> 8)) << odl[oi];
                f = e / (rf >> 8);
                if (f > 2) f = f - 1;
                qr = rf / r;
                while (f >= 2 && f <= 513) begin
                    vco = longint'(qr) * longint'(f);
                    if (vco >= 100_000_000 &&
                        (vco <= 500_000_000 || (tg > 500_000_000 && vco <= 640_000_000))) begin
                        o = vco >> odl[oi];
                        if (o >= lo && o <= hi) begin
                            sc = longint'((qr - ref33) / phden) + (vco - 100_000_000) / 390625;
                            if (!fnd || (sc >= bsc && odl[oi] != 0)) begin
                                fnd = 1; br = r; bf = f; bod = odl[oi]; bclk = o; bsc = sc;
                            end
                        end
                    end
                    f++;
                end
            end
        end
        bp = (bod >= 2) ? 3 : bod;
        if (!fnd) begin br = 0; bf = 0; bp = 0; bclk = 0; end
    endtask

    task automatic pulse_start(input int unsigned rf, input int unsigned tg);
        @(negedge clk);
        ref_hz = rf; tgt_hz = tg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int k = 0;
        while (!done && k < 60_000) begin
            @(negedge clk);
            k++;
        end
        chk(req, "done seen before timeout", done, 1);
    endtask

    task automatic compare(input string req, input int unsigned rf, input int unsigned tg);
        bit fnd; int unsigned br, bf, bp; longint bclk;
        model(rf, tg, fnd, br, bf, bp, bclk);
        chk(req, "found", found, fnd);
        chk(req, "r_sel", r_sel, br);
        chk(req, "f_sel", f_sel, bf);
        chk(req, "p_code", p_code, bp);
        chk(req, "out_hz", out_hz, bclk);
    endtask

    task automatic t_reset;
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "done after reset", done, 0);
        chk("R8", "found after reset", found, 0);
        chk("R8", "out_hz after reset", out_hz, 0);
    endtask

    task automatic t_nominal;
        pulse_start(REFC, 100_000_000);
        chk("R1", "busy after start", busy, 1);
        wait_done("R1");
        chk("R1", "busy low with done", busy, 0);
        compare("R4", REFC, 100_000_000);
        compare("R6", REFC, 100_000_000);
        chk("R7", "p_code for shift 2 winner", p_code, 3);
        chk("R3", "out within upper edge", (out_hz <= 100_000_000 + (100_000_000 >> 8)), 1);
        chk("R3", "out within lower edge", (out_hz >= 100_000_000 - (100_000_000 >> 8)), 1);
        @(negedge clk);
        chk("R1", "done lasts one cycle", done, 0);
    endtask

    task automatic t_hold;
        logic [31:0] h; logic [5:0] r; logic [9:0] f;
        h = out_hz; r = r_sel; f = f_sel;
        ref_hz = 32'd1000; tgt_hz = 32'd5;
        repeat (20) @(negedge clk);
        chk("R9", "out_hz held", out_hz, h);
        chk("R9", "r_sel held", r_sel, r);
        chk("R9", "f_sel held", f_sel, f);
        chk("R9", "no spurious done", done, 0);
    endtask

    task automatic t_ignore_start;
        pulse_start(REFC, 250_000_000);
        repeat (100) @(negedge clk);
        ref_hz = 20_000_000; tgt_hz = 1_000_000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2", "still busy after stray start", busy, 1);
        wait_done("R2");
        compare("R2", REFC, 250_000_000);
    endtask

    task automatic t_override;
        pulse_start(REFC, 520_000_000);
        wait_done("R5");
        compare("R5", REFC, 520_000_000);
        chk("R5", "found above restricted limit", found, 1);
        chk("R7", "p_code for shift 0", p_code, 0);
    endtask

    task automatic t_none;
        pulse_start(REFC, 1_000_000);
        wait_done("R8");
        chk("R8", "found low", found, 0);
        chk("R8", "r_sel zero", r_sel, 0);
        chk("R8", "f_sel zero", f_sel, 0);
        chk("R8", "p_code zero", p_code, 0);
        chk("R8", "out_hz zero", out_hz, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nominal();
        t_hold();
        t_ignore_start();
        t_override();
        t_none();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule